// File: doc/BRIEF.md
# Error Log Scan Controller

This block sits next to a memory error-logging array and runs a hardware search through it. Software writes one 16-bit command word. The word carries a start address, a scan request, a flag that turns off error correction on writes, and a choice between the upper and lower 512K logging bank. When the scan request is set, the engine reads the array one entry at a time, counting upward from the loaded address. It parks on the first entry whose error flag is set.

While parked, the counter shows the address of the faulty entry. A status-read pulse takes that address and lets the engine carry on from the next entry, with no further command needed. The scan ends when the counter wraps from the last entry back to zero.

A ready flag reads low while the engine is stepping. It rises a fixed number of cycles after the engine parks or finishes. That number comes from the clock frequency in MHz times a delay in microseconds. A master clear stops a scan but leaves the address register as it is. The correction-disable flag can be cleared from several sources.

The array port is a plain synchronous read with one cycle of latency. It has no back-pressure: a read is issued every second cycle while stepping, and the returned error flag is used in the cycle after the read. All command and status pins are single-cycle level or pulse signals.

Top module: `errlog_scan_ctl`

## Requirements
- R1: Command word fields use the numbering 0 = MSB, 15 = LSB.
  - Bit 3 (`cmd_word[12]`) requests a scan.
  - Bit 4 (`cmd_word[11]`) sets the correction-disable flag.
  - Bit 5 (`cmd_word[10]`) selects the bank.
  - Bits 6..15 (`cmd_word[9:0]`) hold the start address, of which the low ADDR_W bits are used.
- R2: A scan reads entries upward from the start address, one entry every two cycles. When the last entry (2^ADDR_W-1) shows no error, the scan completes and `sts_addr` reads 0.
- R3: The engine parks on an entry whose error flag is 1, and `sts_addr` holds that entry's address. It stays parked until `sts_rd` is pulsed. After that pulse it resumes with the next address.
- R4: `ready` is 0 while the engine steps through entries. It becomes 1 exactly DELAY cycles (CLK_MHZ*DELAY_US) after the engine parks or completes.
- R5: `mclr` aborts a scan. No further array reads are issued, and `ready` is 1 in the next cycle.
- R6: `mclr` does not change the address register (`sts_addr`).
- R7: The correction-disable flag is cleared by any of the following:
  - reset (power-on);
  - `io_rst`;
  - `pfw`;
  - `copy_done`;
  - `mclr`;
  - a command write with bit 4 = 0.
- R8: The bank select (1 = upper, 0 = lower) takes the new bit 5 value one cycle after the command write.
- R9: `sts_rd` while the engine is not parked leaves the address and `ready` unchanged.
- R10: A command write with the scan bit set during a running scan restarts the scan from the newly loaded address.
- R11: A command write with the scan bit clear loads the address, ends any scan or park, and makes `ready` 1 in the next cycle.
- R12: When the last entry has an error, the engine parks at it. The following `sts_rd` completes the scan: the counter wraps to 0 and `ready` rises DELAY cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word |
| mclr | input | 1 | Master clear command pulse |
| io_rst | input | 1 | I/O reset pulse |
| pfw | input | 1 | Power-fail warning pulse |
| copy_done | input | 1 | Read-copy or write-copy finished |
| sts_rd | input | 1 | Status read pulse |
| log_rd_en | output | 1 | Array read enable |
| log_addr | output | ADDR_W | Array read address |
| log_err | input | 1 | Error flag of the entry read in the previous cycle |
| sts_addr | output | ADDR_W | Address counter (parked address) |
| ready | output | 1 | Read/write OK status |
| wec_dis | output | 1 | Write error-correction disable flag |
| bank_upper | output | 1 | 1 = upper 512K bank selected |

## Verification
Each halt result has a predicted arrival time. Counting from the edge that starts or resumes stepping at address `f`, with the next error or the end at address `t`, `ready` is due exactly 2·(t−f)+2+DELAY edges later. The one exception is a resume that completes directly from a park at the last entry, where `ready` is due after DELAY edges. The bench counts edges until `ready` is first seen high at a falling edge and compares the count with that prediction, so any early rise or late rise is reported.

The bank and flag checks sample at the falling edge right after the write edge. The abort and stop checks sample `ready` at the falling edge after the pulse. The scan sweep covers every start address on a 16-entry array under eight error maps.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int CMD_W     = 16;
  // field positions: bit k counted from the MSB sits at index CMD_W-1-k
  localparam int FLD_SCAN  = CMD_W - 1 - 3;
  localparam int FLD_WEC   = CMD_W - 1 - 4;
  localparam int FLD_BANK  = CMD_W - 1 - 5;
  localparam int ADDR_MAXW = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_HALT
  } scan_st_t;
endpackage

// File: rtl/errlog_cmd_reg.sv
module errlog_cmd_reg
  import errlog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_wec,
  input  logic cmd_bank,
  input  logic mclr,
  input  logic io_rst,
  input  logic pfw,
  input  logic copy_done,
  output logic wec_dis,
  output logic bank_upper
);
  logic clr_any;
  assign clr_any = mclr | io_rst | pfw | copy_done | (cmd_wr & ~cmd_wec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wec_dis    <= 1'b0;
      bank_upper <= 1'b0;
    end else begin
      if (clr_any)
        wec_dis <= 1'b0;
      else if (cmd_wr)
        wec_dis <= 1'b1;
      if (cmd_wr)
        bank_upper <= cmd_bank;
    end
  end

  AST_WEC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr | io_rst | pfw | copy_done) |=> !wec_dis); // R7
  AST_BANK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> bank_upper == $past(cmd_bank)); // R8
endmodule

// File: rtl/errlog_rdy_timer.sv
module errlog_rdy_timer #(
  parameter int DELAY_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic restart,
  input  logic force_rdy,
  output logic ready
);
  localparam int TW = $clog2(DELAY_CYC + 1);
  localparam logic [TW-1:0] DLY = TW'(DELAY_CYC);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      tcnt <= DLY;
    else if (force_rdy)
      tcnt <= DLY;
    else if (busy | restart)
      tcnt <= '0;
    else if (tcnt != DLY)
      tcnt <= tcnt + 1'b1;
  end

  assign ready = !busy && (tcnt == DLY);

  AST_TCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= DLY); // R4
  AST_FORCE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    force_rdy |=> tcnt == DLY); // R5
endmodule

// File: rtl/errlog_scan_fsm.sv
module errlog_scan_fsm
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              cmd_wr,
  input  logic              cmd_scan,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              sts_rd,
  input  logic              log_err,
  output logic              log_rd_en,
  output logic [ADDR_W-1:0] cnt,
  output logic              busy,
  output logic              fin_from_halt
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  scan_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (cmd_wr) begin
      cnt <= cmd_addr;
      st  <= (cmd_scan && !mclr) ? ST_FETCH : ST_IDLE;
    end else if (mclr) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          if (log_err) begin
            st <= ST_HALT;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= (cnt == LAST) ? ST_IDLE : ST_FETCH;
          end
        end
        ST_HALT: begin
          if (sts_rd) begin
            cnt <= cnt + 1'b1;
            st  <= (cnt == LAST) ? ST_IDLE : ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign log_rd_en     = (st == ST_FETCH);
  assign busy          = (st == ST_FETCH) || (st == ST_CHECK);
  assign fin_from_halt = (st == ST_HALT) && sts_rd && !mclr && !cmd_wr && (cnt == LAST);

  AST_MCLR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr && !cmd_wr) |=> (st == ST_IDLE) && !log_rd_en); // R5
  AST_MCLR_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr && !cmd_wr) |=> $stable(cnt)); // R6
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && !sts_rd && !cmd_wr && !mclr) |=> (st == ST_HALT) && $stable(cnt)); // R3
  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && sts_rd && !cmd_wr && !mclr && cnt != LAST)
      |=> (st == ST_FETCH) && (cnt == $past(cnt) + 1'b1)); // R3
  AST_IDLE_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && sts_rd && !cmd_wr && !mclr) |=> $stable(cnt) && (st == ST_IDLE)); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_scan && !mclr) |=> (st == ST_FETCH) && (cnt == $past(cmd_addr))); // R10
endmodule

// File: rtl/errlog_scan_ctl.sv
module errlog_scan_ctl
  import errlog_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CLK_MHZ  = 50,
  parameter int DELAY_US = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [15:0]       cmd_word,
  input  logic              mclr,
  input  logic              io_rst,
  input  logic              pfw,
  input  logic              copy_done,
  input  logic              sts_rd,
  output logic              log_rd_en,
  output logic [ADDR_W-1:0] log_addr,
  input  logic              log_err,
  output logic [ADDR_W-1:0] sts_addr,
  output logic              ready,
  output logic              wec_dis,
  output logic              bank_upper
);
  localparam int DELAY_CYC = CLK_MHZ * DELAY_US;

  logic              cmd_scan, cmd_wec, cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] cnt;
  logic              busy, fin_from_halt, force_rdy;
  logic              unused_bits;

  assign cmd_scan    = cmd_word[FLD_SCAN];
  assign cmd_wec     = cmd_word[FLD_WEC];
  assign cmd_bank    = cmd_word[FLD_BANK];
  assign cmd_addr    = cmd_word[ADDR_W-1:0];
  assign unused_bits = ^cmd_word;

  assign force_rdy = mclr | (cmd_wr & ~cmd_scan);

  errlog_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_wec    (cmd_wec),
    .cmd_bank   (cmd_bank),
    .mclr       (mclr),
    .io_rst     (io_rst),
    .pfw        (pfw),
    .copy_done  (copy_done),
    .wec_dis    (wec_dis),
    .bank_upper (bank_upper)
  );

  errlog_scan_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .mclr          (mclr),
    .cmd_wr        (cmd_wr),
    .cmd_scan      (cmd_scan),
    .cmd_addr      (cmd_addr),
    .sts_rd        (sts_rd),
    .log_err       (log_err),
    .log_rd_en     (log_rd_en),
    .cnt           (cnt),
    .busy          (busy),
    .fin_from_halt (fin_from_halt)
  );

  errlog_rdy_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .restart   (fin_from_halt),
    .force_rdy (force_rdy),
    .ready     (ready)
  );

  assign log_addr = cnt;
  assign sts_addr = cnt;

  initial begin
    assert (ADDR_W >= 1 && ADDR_W <= ADDR_MAXW);
  end

  AST_NOT_READY_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    log_rd_en |-> !ready); // R4
  AST_STOP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_scan) |=> ready && !log_rd_en); // R11
endmodule

// File: tb/errlog_scan_ctl_bench.sv
module errlog_scan_ctl_bench;
  localparam int AW    = 4;
  localparam int NENT  = 1 << AW;
  localparam int LAST  = NENT - 1;
  localparam int MHZ   = 3;
  localparam int US    = 2;
  localparam int DELAY = MHZ * US;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [15:0]   cmd_word = '0;
  logic          mclr = 1'b0, io_rst = 1'b0, pfw = 1'b0, copy_done = 1'b0;
  logic          sts_rd = 1'b0;
  logic          log_rd_en;
  logic [AW-1:0] log_addr;
  logic          log_err = 1'b0;
  logic [AW-1:0] sts_addr;
  logic          ready, wec_dis, bank_upper;
  logic [NENT-1:0] err_map = '0;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  errlog_scan_ctl #(.ADDR_W(AW), .CLK_MHZ(MHZ), .DELAY_US(US)) u_errlog_scan_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .mclr(mclr), .io_rst(io_rst), .pfw(pfw), .copy_done(copy_done),
    .sts_rd(sts_rd), .log_rd_en(log_rd_en), .log_addr(log_addr),
    .log_err(log_err), .sts_addr(sts_addr), .ready(ready),
    .wec_dis(wec_dis), .bank_upper(bank_upper)
  );

  always_ff @(posedge clk) begin
    if (log_rd_en) log_err <= err_map[log_addr];
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit scan, input bit wec, input bit bank, input int a);
    return {3'b000, scan, wec, bank, 10'(a)};
  endfunction

  task automatic do_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(posedge clk); #1;
    cmd_wr = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(posedge clk); #1;
    sig = 1'b0;
  endtask

  // counts edges from the launch edge until ready is seen high
  task automatic edges_to_ready(output int e);
    e = 1;
    forever begin
      @(negedge clk);
      if (ready || e > 400) break;
      @(posedge clk);
      e++;
    end
  endtask

  function automatic logic [NENT-1:0] map_of(input int p);
    case (p)
      0: return '0;
      1: return '1;
      2: return NENT'(1) << LAST;
      3: return NENT'(1);
      default: return NENT'((p * 40503) ^ (p * p * 97) ^ (p << 9));
    endcase
  endfunction

  task automatic run_scan(input int s);
    int from, e, a;
    bit done;
    do_cmd(mk(1'b1, 1'b0, 1'b0, s));
    from = s;
    done = 1'b0;
    while (!done) begin
      a = -1;
      for (int k = from; k <= LAST; k++)
        if (a < 0 && err_map[k]) a = k;
      edges_to_ready(e);
      if (a >= 0) begin
        check("R4 halt ready time", e, 2 * (a - from) + 3 + DELAY);
        check("R3 halted address", int'(sts_addr), a);
        pulse(sts_rd);
        if (a == LAST) begin
          edges_to_ready(e);
          check("R12 finish from last park", e, DELAY + 1);
          check("R12 wrapped address", int'(sts_addr), 0);
          done = 1'b1;
        end else begin
          from = a + 1;
        end
      end else begin
        check("R2 completion ready time", e, 2 * (LAST - from) + 3 + DELAY);
        check("R2 wrapped address", int'(sts_addr), 0);
        done = 1'b1;
      end
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0, e, rd_seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset ready", ready, 1);
    check("R7 reset wec", wec_dis, 0);
    check("R8 reset bank", bank_upper, 0);
    check("R2 reset no read", log_rd_en, 0);

    // R8 / R1 bank select timing
    do_cmd(mk(1'b0, 1'b0, 1'b1, 3));
    @(negedge clk);
    check("R8 bank upper", bank_upper, 1);
    check("R1 address field", int'(sts_addr), 3);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = mk(1'b0, 1'b0, 1'b0, 3);
    #2 check("R8 bank before edge", bank_upper, 1);
    @(posedge clk); #1 cmd_wr = 1'b0;
    check("R8 bank lower", bank_upper, 0);

    // R7 each clear source
    for (int src = 0; src < 5; src++) begin
      do_cmd(mk(1'b0, 1'b1, 1'b0, 3));
      check("R7 wec set", wec_dis, 1);
      case (src)
        0: pulse(io_rst);
        1: pulse(pfw);
        2: pulse(copy_done);
        3: pulse(mclr);
        default: do_cmd(mk(1'b0, 1'b0, 1'b0, 3));
      endcase
      check("R7 wec cleared", wec_dis, 0);
    end

    // R9 status read while idle
    do_cmd(mk(1'b0, 1'b0, 1'b0, 5));
    pulse(sts_rd);
    @(negedge clk);
    check("R9 idle read addr", int'(sts_addr), 5);
    check("R9 idle read ready", ready, 1);

    // R2 R3 R4 R12 sweep
    for (int p = 0; p < 8; p++) begin
      err_map = map_of(p);
      for (int s = 0; s < NENT; s++) run_scan(s);
    end

    // R5 / R6 abort
    err_map = '0;
    do_cmd(mk(1'b1, 1'b0, 1'b0, 0));
    repeat (5) @(posedge clk);
    #1 a0 = int'(sts_addr);
    pulse(mclr);
    @(negedge clk);
    check("R5 ready after abort", ready, 1);
    check("R6 addr kept by mclr", int'(sts_addr), a0);
    rd_seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (log_rd_en) rd_seen++;
    end
    check("R5 no reads after abort", rd_seen, 0);
    do_cmd(mk(1'b0, 1'b0, 1'b0, 9));
    pulse(mclr);
    check("R6 idle addr kept", int'(sts_addr), 9);

    // R10 restart
    err_map = NENT'(1) << 12;
    do_cmd(mk(1'b1, 1'b0, 1'b0, 2));
    repeat (4) @(posedge clk);
    do_cmd(mk(1'b1, 1'b0, 1'b0, 10));
    edges_to_ready(e);
    check("R10 restart ready time", e, 2 * (12 - 10) + 3 + DELAY);
    check("R10 restart halt addr", int'(sts_addr), 12);

    // R11 stop from park and from stepping
    do_cmd(mk(1'b0, 1'b0, 1'b0, 5));
    check("R11 stop ready", ready, 1);
    check("R11 stop addr", int'(sts_addr), 5);
    err_map = '0;
    do_cmd(mk(1'b1, 1'b0, 1'b0, 0));
    repeat (3) @(posedge clk);
    do_cmd(mk(1'b0, 1'b0, 1'b0, 7));
    check("R11 stop while stepping ready", ready, 1);
    repeat (4) @(negedge clk);
    check("R11 no read after stop", log_rd_en, 0);
    check("R11 addr after stop", int'(sts_addr), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule